// File: doc/BRIEF.md
# Page-Safe Payload Descriptor Splitter

This block turns the start address of a fixed-size payload held in a paged buffer into one or two DMA transfer descriptors. Each descriptor carries an address and a byte length. No descriptor ever runs past the end of a page. When the payload fits in the space left on its page, one descriptor covers all of it. When it does not fit, a head descriptor takes the bytes up to the page end, and a tail descriptor starts exactly on the next page and carries the rest.

A request also carries flags that tell the block whether the packet opens a frame, sits in the middle of a frame, or closes a frame. From these flags the block decides whether completion status writeback and an interrupt are wanted. It also gives the total descriptor count of the packet's descriptor block. That count is one higher when the payload is split. The count is merged into the low bits of the block's base address, which gives the pointer word that a previous block would branch through. Requests arrive on a valid/ready handshake. Descriptors leave on a second valid/ready handshake, one per cycle.

Top module: `dsc_splitter`

## Requirements
- R1: After reset `dsc_valid` is 0 and `req_ready` is 1.
- R2: If the bytes left to the page end, PAGE_BYTES minus (addr mod PAGE_BYTES), are 480 or more, exactly one descriptor is emitted: address = request address, length = 480, `dsc_last` = 1. A room of exactly 480 does not split.
- R3: If that room is below 480, the first descriptor has address = request address, length = room and `dsc_last` = 0.
- R4: In a split, the second descriptor has address = the next page boundary (the page number plus one, with the page offset zero, wrapping at the top of the address space), length = 480 minus room, and `dsc_last` = 1.
- R5: While a descriptor is valid, `blk_count` is 4 for an unsplit packet and 5 for a split one.
- R6: `dsc_status_req` and `dsc_irq_req` are both 1 when any of `req_first`, `req_mid`, `req_last` was 1 at acceptance, and both 0 otherwise.
- R7: `link_word` equals `req_blk_base` with its low 4 bits cleared, OR `blk_count`. Whatever the low 4 bits of the base were, they have no effect.
- R8: While `dsc_valid` is 1 and `dsc_ready` is 0, the descriptor outputs hold steady. `req_ready` stays 0 from acceptance until the last descriptor is taken, and a `req_valid` seen during that time is ignored.
- R9: With `dsc_ready` held at 1, the descriptors of a packet appear on consecutive cycles, starting the cycle after acceptance. `req_ready` returns to 1 in the cycle after the last descriptor is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Payload start address |
| req_first | input | 1 | Packet opens a frame |
| req_mid | input | 1 | Packet is the mid-frame marker |
| req_last | input | 1 | Packet closes a frame |
| req_blk_base | input | ADDR_W | Base address of the packet's descriptor block |
| dsc_valid | output | 1 | Descriptor present |
| dsc_ready | input | 1 | Consumer takes the descriptor |
| dsc_addr | output | ADDR_W | Descriptor start address |
| dsc_len | output | LEN_W | Descriptor byte length |
| dsc_last | output | 1 | Final descriptor of the packet |
| dsc_status_req | output | 1 | Status writeback wanted |
| dsc_irq_req | output | 1 | Interrupt wanted |
| blk_count | output | CNT_W | Descriptors in the packet block |
| link_word | output | ADDR_W | Block base merged with the count |

## Verification
The bench aims at the split threshold. A room of exactly 480 must give a single descriptor, and a room of 479 must give a 479/1 split. A design that compares with "at most" instead of "fewer than" would emit a zero-length tail, and a design with an off-by-one in the offset arithmetic would give a head that crosses the page. An address on the last byte of a page, and an address near the top of the address space, test the tail address. A design that adds the payload length there, instead of stepping to the page boundary, or that drops the carry, sends the tail to the wrong place. Stalls on `dsc_ready` with a competing request test the handshake: a design that re-accepts during a stall would overwrite the pending descriptor. A block base with nonzero low bits tests that the count replaces those bits rather than being ORed onto them.

// File: rtl/dsc_splitter_pkg.sv
package dsc_splitter_pkg;

   typedef enum logic [1:0] {
      EMIT_IDLE = 2'd0,
      EMIT_HEAD = 2'd1,
      EMIT_TAIL = 2'd2
   } emit_state_t;

   typedef struct packed {
      logic opens;
      logic middle;
      logic closes;
   } pkt_role_t;

endpackage

// File: rtl/dsc_page_split.sv
module dsc_page_split #(
   parameter int ADDR_W        = 32,
   parameter int PAGE_BYTES    = 4096,
   parameter int PAYLOAD_BYTES = 480,
   parameter int OFF_W         = $clog2(PAGE_BYTES),
   parameter int LEN_W         = OFF_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              split,
   output logic [LEN_W-1:0]  head_len,
   output logic [LEN_W-1:0]  tail_len,
   output logic [ADDR_W-1:0] tail_addr
);
   localparam int PN_W = ADDR_W - OFF_W;
   localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);
   localparam logic [LEN_W-1:0] PAY_L  = LEN_W'(PAYLOAD_BYTES);

   logic [OFF_W-1:0] page_off;
   logic [LEN_W-1:0] room;
   logic [PN_W-1:0]  next_page;

   assign page_off  = addr[OFF_W-1:0];
   assign room      = PAGE_L - {1'b0, page_off};
   assign next_page = addr[ADDR_W-1:OFF_W] + PN_W'(1);

   generate
      if (PAYLOAD_BYTES == PAGE_BYTES) begin : g_full_page
         // a page-sized payload splits whenever it is not page aligned
         assign split = (page_off != '0);
      end else begin : g_short
         assign split = (room < PAY_L);
      end
   endgenerate

   assign head_len  = split ? room : PAY_L;
   assign tail_len  = PAY_L - room;
   assign tail_addr = {next_page, {OFF_W{1'b0}}};
endmodule

// File: rtl/dsc_role_flags.sv
module dsc_role_flags
   import dsc_splitter_pkg::*;
(
   input  pkt_role_t role,
   output logic      want_status,
   output logic      want_irq
);
   logic marked;
   assign marked      = role.opens | role.middle | role.closes;
   assign want_status = marked;
   assign want_irq    = marked;
endmodule

// File: rtl/dsc_emit_fsm.sv
module dsc_emit_fsm
   import dsc_splitter_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 13,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              split_in,
   input  logic [ADDR_W-1:0] head_addr_in,
   input  logic [LEN_W-1:0]  head_len_in,
   input  logic [ADDR_W-1:0] tail_addr_in,
   input  logic [LEN_W-1:0]  tail_len_in,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [ADDR_W-1:0] link_in,
   input  logic              status_in,
   input  logic              irq_in,
   output logic              idle,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [LEN_W-1:0]  out_len,
   output logic              out_last,
   output logic              out_status,
   output logic              out_irq,
   output logic [CNT_W-1:0]  out_cnt,
   output logic [ADDR_W-1:0] out_link
);
   emit_state_t        state_q, state_d;
   logic               split_q;
   logic [ADDR_W-1:0]  head_addr_q, tail_addr_q, link_q;
   logic [LEN_W-1:0]   head_len_q, tail_len_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               status_q, irq_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         EMIT_IDLE: if (take) state_d = EMIT_HEAD;
         EMIT_HEAD: if (out_ready) state_d = split_q ? EMIT_TAIL : EMIT_IDLE;
         EMIT_TAIL: if (out_ready) state_d = EMIT_IDLE;
         default:   state_d = EMIT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= EMIT_IDLE;
         split_q     <= 1'b0;
         head_addr_q <= '0;
         head_len_q  <= '0;
         tail_addr_q <= '0;
         tail_len_q  <= '0;
         cnt_q       <= '0;
         link_q      <= '0;
         status_q    <= 1'b0;
         irq_q       <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take && state_q == EMIT_IDLE) begin
            split_q     <= split_in;
            head_addr_q <= head_addr_in;
            head_len_q  <= head_len_in;
            tail_addr_q <= tail_addr_in;
            tail_len_q  <= tail_len_in;
            cnt_q       <= cnt_in;
            link_q      <= link_in;
            status_q    <= status_in;
            irq_q       <= irq_in;
         end
      end
   end

   assign idle       = (state_q == EMIT_IDLE);
   assign out_valid  = (state_q == EMIT_HEAD) || (state_q == EMIT_TAIL);
   assign out_addr   = (state_q == EMIT_TAIL) ? tail_addr_q : head_addr_q;
   assign out_len    = (state_q == EMIT_TAIL) ? tail_len_q  : head_len_q;
   assign out_last   = (state_q == EMIT_TAIL) || !split_q;
   assign out_status = status_q;
   assign out_irq    = irq_q;
   assign out_cnt    = cnt_q;
   assign out_link   = link_q;
endmodule

// File: rtl/dsc_splitter.sv
module dsc_splitter
   import dsc_splitter_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int PAGE_BYTES    = 4096,
   parameter int PAYLOAD_BYTES = 480,
   parameter int BASE_DESC     = 4,
   parameter int LINK_LSB      = 4,
   parameter int OFF_W         = $clog2(PAGE_BYTES),
   parameter int LEN_W         = OFF_W + 1,
   parameter int CNT_W         = $clog2(BASE_DESC + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_first,
   input  logic              req_mid,
   input  logic              req_last,
   input  logic [ADDR_W-1:0] req_blk_base,
   output logic              dsc_valid,
   input  logic              dsc_ready,
   output logic [ADDR_W-1:0] dsc_addr,
   output logic [LEN_W-1:0]  dsc_len,
   output logic              dsc_last,
   output logic              dsc_status_req,
   output logic              dsc_irq_req,
   output logic [CNT_W-1:0]  blk_count,
   output logic [ADDR_W-1:0] link_word
);
   localparam logic [ADDR_W-1:0] LINK_MASK = ADDR_W'((64'd1 << LINK_LSB) - 64'd1);

   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES > PAGE_BYTES) begin : g_bad_pay
         $error("PAYLOAD_BYTES must lie in 1..PAGE_BYTES");
      end
      if ((BASE_DESC + 1) >= (1 << LINK_LSB)) begin : g_bad_link
         $error("descriptor count does not fit below LINK_LSB");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for PAGE_BYTES");
      end
   endgenerate

   pkt_role_t          role;
   logic               split, want_status, want_irq, idle, take;
   logic [LEN_W-1:0]   head_len, tail_len;
   logic [ADDR_W-1:0]  tail_addr, link_calc;
   logic [CNT_W-1:0]   cnt_calc;

   assign role      = '{opens: req_first, middle: req_mid, closes: req_last};
   assign req_ready = idle;
   assign take      = req_valid & idle;
   assign cnt_calc  = split ? CNT_W'(BASE_DESC + 1) : CNT_W'(BASE_DESC);
   assign link_calc = (req_blk_base & ~LINK_MASK) | ADDR_W'(cnt_calc);

   dsc_page_split #(
      .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PAYLOAD_BYTES(PAYLOAD_BYTES),
      .OFF_W(OFF_W), .LEN_W(LEN_W)
   ) u_split (
      .addr(req_addr), .split(split), .head_len(head_len),
      .tail_len(tail_len), .tail_addr(tail_addr)
   );

   dsc_role_flags u_role (
      .role(role), .want_status(want_status), .want_irq(want_irq)
   );

   dsc_emit_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .take(take), .split_in(split),
      .head_addr_in(req_addr), .head_len_in(head_len),
      .tail_addr_in(tail_addr), .tail_len_in(tail_len),
      .cnt_in(cnt_calc), .link_in(link_calc),
      .status_in(want_status), .irq_in(want_irq),
      .idle(idle), .out_valid(dsc_valid), .out_ready(dsc_ready),
      .out_addr(dsc_addr), .out_len(dsc_len), .out_last(dsc_last),
      .out_status(dsc_status_req), .out_irq(dsc_irq_req),
      .out_cnt(blk_count), .out_link(link_word)
   );
endmodule

// File: rtl/dsc_splitter_chk.sv
module dsc_splitter_chk #(
   parameter int ADDR_W        = 32,
   parameter int PAGE_BYTES    = 4096,
   parameter int PAYLOAD_BYTES = 480,
   parameter int BASE_DESC     = 4,
   parameter int OFF_W         = 12,
   parameter int LEN_W         = 13,
   parameter int CNT_W         = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              dsc_valid,
   input logic              dsc_ready,
   input logic [ADDR_W-1:0] dsc_addr,
   input logic [LEN_W-1:0]  dsc_len,
   input logic              dsc_last,
   input logic              dsc_status_req,
   input logic              dsc_irq_req,
   input logic [CNT_W-1:0]  blk_count
);
   logic [LEN_W-1:0] end_off;
   assign end_off = {1'b0, dsc_addr[OFF_W-1:0]} + dsc_len;

   AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid |-> (end_off <= LEN_W'(PAGE_BYTES))); // R3

   AST_TAIL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_valid && dsc_ready && !dsc_last) |=>
      (dsc_valid && dsc_last && dsc_addr[OFF_W-1:0] == '0)); // R4

   AST_LENGTHS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_valid && dsc_ready && !dsc_last) |=>
      ((dsc_len + $past(dsc_len)) == LEN_W'(PAYLOAD_BYTES))); // R4

   AST_WHOLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_valid && dsc_len == LEN_W'(PAYLOAD_BYTES)) |->
      (dsc_last && blk_count == CNT_W'(BASE_DESC))); // R5

   AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid |-> (dsc_status_req == dsc_irq_req)); // R6

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid |-> !req_ready); // R8

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_valid && !dsc_ready) |=>
      (dsc_valid && $stable(dsc_addr) && $stable(dsc_len) && $stable(dsc_last))); // R8

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> dsc_valid); // R9
endmodule

bind dsc_splitter dsc_splitter_chk #(
   .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PAYLOAD_BYTES(PAYLOAD_BYTES),
   .BASE_DESC(BASE_DESC), .OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_addr(dsc_addr),
   .dsc_len(dsc_len), .dsc_last(dsc_last), .dsc_status_req(dsc_status_req),
   .dsc_irq_req(dsc_irq_req), .blk_count(blk_count)
);

// File: tb/dsc_splitter_test.sv
module dsc_splitter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_first = 1'b0, req_mid = 1'b0, req_last = 1'b0;
   logic [31:0] req_blk_base = '0;
   logic        dsc_valid;
   logic        dsc_ready = 1'b0;
   logic [31:0] dsc_addr;
   logic [12:0] dsc_len;
   logic        dsc_last, dsc_status_req, dsc_irq_req;
   logic [2:0]  blk_count;
   logic [31:0] link_word;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   dsc_splitter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_first(req_first), .req_mid(req_mid),
      .req_last(req_last), .req_blk_base(req_blk_base), .dsc_valid(dsc_valid),
      .dsc_ready(dsc_ready), .dsc_addr(dsc_addr), .dsc_len(dsc_len),
      .dsc_last(dsc_last), .dsc_status_req(dsc_status_req),
      .dsc_irq_req(dsc_irq_req), .blk_count(blk_count), .link_word(link_word)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one packet: accept, optional stall with a competing request, drain
   task automatic run_pkt(input logic [31:0] a, input logic f, input logic m,
                          input logic l, input logic [31:0] base, input int stall);
      int          room;
      bit          split;
      logic [2:0]  cnt;
      logic        flag;
      logic [31:0] link, tail;
      room  = 4096 - int'(a & 32'hFFF);
      split = (room < 480);
      cnt   = split ? 3'd5 : 3'd4;
      flag  = f | m | l;
      link  = (base & 32'hFFFF_FFF0) | {29'd0, cnt};
      tail  = (a & 32'hFFFF_F000) + 32'h1000;

      @(negedge clk);
      chk("R8", "req_ready idle", {63'd0, req_ready}, 64'd1);
      req_addr = a; req_first = f; req_mid = m; req_last = l;
      req_blk_base = base; req_valid = 1'b1; dsc_ready = 1'b0;
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk("R9", "valid after accept", {63'd0, dsc_valid}, 64'd1);
      chk(split ? "R3" : "R2", "head addr", {32'd0, dsc_addr}, {32'd0, a});
      chk(split ? "R3" : "R2", "head len", {51'd0, dsc_len}, split ? 64'(room) : 64'd480);
      chk(split ? "R3" : "R2", "head last", {63'd0, dsc_last}, {63'd0, !split});
      chk("R5", "count", {61'd0, blk_count}, {61'd0, cnt});
      chk("R6", "status", {63'd0, dsc_status_req}, {63'd0, flag});
      chk("R6", "irq", {63'd0, dsc_irq_req}, {63'd0, flag});
      chk("R7", "link", {32'd0, link_word}, {32'd0, link});
      chk("R8", "busy not ready", {63'd0, req_ready}, 64'd0);
      for (int i = 0; i < stall; i++) begin
         req_addr = 32'h0000_0FFF; req_valid = 1'b1;
         @(posedge clk); #1;
         chk("R8", "stall addr", {32'd0, dsc_addr}, {32'd0, a});
         chk("R8", "stall valid", {63'd0, dsc_valid}, 64'd1);
      end
      req_valid = 1'b0;
      dsc_ready = 1'b1;
      @(posedge clk); #1;
      if (split) begin
         chk("R9", "tail valid", {63'd0, dsc_valid}, 64'd1);
         chk("R4", "tail addr", {32'd0, dsc_addr}, {32'd0, tail});
         chk("R4", "tail len", {51'd0, dsc_len}, 64'(480 - room));
         chk("R4", "tail last", {63'd0, dsc_last}, 64'd1);
         @(posedge clk); #1;
      end
      dsc_ready = 1'b0;
      chk("R9", "drained", {63'd0, dsc_valid}, 64'd0);
      chk("R9", "ready back", {63'd0, req_ready}, 64'd1);
   endtask

   task automatic t_reset;
      chk("R1", "valid in reset", {63'd0, dsc_valid}, 64'd0);
      chk("R1", "ready in reset", {63'd0, req_ready}, 64'd1);
   endtask

   initial begin
      #200000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2;
      t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      run_pkt(32'h1000_0000, 1'b1, 1'b0, 1'b0, 32'h2000_0000, 0); // aligned, R2
      run_pkt(32'h1000_0E20, 1'b0, 1'b0, 1'b0, 32'h2000_0040, 0); // room 480, R2
      run_pkt(32'h1000_0E21, 1'b0, 1'b1, 1'b0, 32'h2000_0080, 0); // room 479, R3 R4
      run_pkt(32'h1000_0FFF, 1'b0, 1'b0, 1'b1, 32'h2000_00C0, 0); // room 1
      run_pkt(32'hFFFF_FF00, 1'b0, 1'b0, 1'b0, 32'hABCD_123F, 2); // wrap, R7 R8
      run_pkt(32'h0000_0800, 1'b0, 1'b0, 1'b0, 32'h0000_0007, 3); // mid page stall
      run_pkt(32'h0000_0F00, 1'b1, 1'b1, 1'b1, 32'h0000_0100, 1);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule